// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a clocked system and an asynchronous static RAM with a byte-wide data bus. The user side offers one word per request through a valid/ready handshake. The request carries the address, a write flag and write data. Read results come back on a data bus with a single-cycle valid strobe. The memory side produces the address and four control strobes: an active-low select, an active-high select, an active-low output enable and an active-low write enable. The bidirectional data pins are split into separate in, out and drive-enable signals.

Every strobe edge falls on a clock edge. Each phase lasts a whole number of cycles. These counts are computed at elaboration from the clock period and from the device's nanosecond minimums, using a ceiling division with a floor of one cycle. A read holds both selects and output enable active until the access time has passed. The block then samples the data. A write first asserts both selects for one setup cycle. It then pulls write enable low and drives the data for the pulse length, and releases everything at a single edge. Every access ends with a turnaround of deselected cycles. These cover the worst-case output float time before the next request is taken.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, the block holds these values: sram_cs_n=1, sram_cs2=0, sram_oe_n=1, sram_we_n=1, sram_dq_oe=0, req_ready=1 and rsp_valid=0. Between accesses the same pin values apply.
- R2: A phase count equals the ceiling of its nanosecond limit divided by CLK_NS, and is at least one cycle. The read count RD_CYC uses the largest of the read-cycle, address-access and output-enable limits; it is 7 at the defaults. rsp_valid is high in the cycle RD_CYC+1 cycles after the cycle in which the read request was accepted.
- R3: During a read, sram_cs_n=0, sram_cs2=1, sram_oe_n=0, sram_we_n=1 and sram_dq_oe=0 hold for exactly RD_CYC consecutive cycles, with the address stable.
- R4: rsp_valid is high for one cycle per read. rsp_rdata carries sram_dq_in as sampled at the clock edge that ends the last access cycle.
- R5: A write asserts both selects with sram_we_n=1 for one cycle. sram_we_n is then low for PUL_CYC cycles, where PUL_CYC is the largest of the write-pulse count, the data-setup count, the select-window count minus one and the write-cycle count minus one. At the defaults PUL_CYC is 6. Address and write data stay stable while sram_we_n is low.
- R6: sram_dq_oe is high only while sram_we_n is low and both selects are active. sram_oe_n and sram_we_n are never low together.
- R7: After every access, all strobes are inactive for HZ_CYC cycles before req_ready rises. HZ_CYC is the float-time count, 3 at the defaults.
- R8: req_ready is high only when no access or turnaround is in progress. A request is taken in a cycle where req_valid and req_ready are both high.
- R9: The device minimums are met and the data bus is never driven from both sides. These minimums are the read and write cycle times, the access times, the write pulse, the select window, the data setup and address stability during the write. A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_in | input | DATA_W | Data arriving from the pins |
| sram_dq_out | output | DATA_W | Data to drive onto the pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench records the cycle number at which each read is accepted. It expects rsp_valid exactly RD_CYC+1 cycles later, and the scoreboard monitor compares both the cycle and the data at the falling edge. Strobe run lengths are checked the same way, also at falling edges: RD_CYC cycles of output enable, PUL_CYC cycles of write enable after one setup cycle, and HZ_CYC deselected cycles before req_ready returns. A behavioural memory model works in nanoseconds and reports any broken minimum or bus contention. It drives wrong data until the access time has passed, so a read sampled too early fails.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_RD   = 3'd1,
      PH_WSU  = 3'd2,
      PH_WPUL = 3'd3,
      PH_TURN = 3'd4
   } phase_e;

   typedef struct packed {
      logic cs_n;
      logic cs2;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } pin_ctl_t;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // ceiling division, never below one cycle
   function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic pin_ctl_t phase_pins(phase_e ph);
      pin_ctl_t p;
      case (ph)
         PH_RD:   p = '{cs_n: 1'b0, cs2: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
         PH_WSU:  p = '{cs_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
         PH_WPUL: p = '{cs_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
         default: p = '{cs_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
   import sram_ctl_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase_nxt,
   output logic   cs_n,
   output logic   cs2,
   output logic   oe_n,
   output logic   we_n,
   output logic   dq_oe
);
   pin_ctl_t pins_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pins_q <= phase_pins(PH_IDLE);
      else        pins_q <= phase_pins(phase_nxt);
   end

   assign cs_n  = pins_q.cs_n;
   assign cs2   = pins_q.cs2;
   assign oe_n  = pins_q.oe_n;
   assign we_n  = pins_q.we_n;
   assign dq_oe = pins_q.dq_oe;

   assert_no_oe_we_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));
   assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!we_n && !cs_n && cs2));
   assert_drive_off_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> !$past(dq_oe));
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CLK_NS = 8,
   parameter int unsigned T_RC_NS  = 55,
   parameter int unsigned T_AA_NS  = 55,
   parameter int unsigned T_OE_NS  = 25,
   parameter int unsigned T_WC_NS  = 55,
   parameter int unsigned T_WP_NS  = 40,
   parameter int unsigned T_CW_NS  = 45,
   parameter int unsigned T_DW_NS  = 20,
   parameter int unsigned T_HZ_NS  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_cs2,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe
);
   localparam int unsigned RD_CYC  = ns_to_cyc(max2(max2(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS);
   localparam int unsigned CW_CYC  = ns_to_cyc(T_CW_NS, CLK_NS);
   localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int unsigned PUL_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                          max2(max2(CW_CYC, 2) - 1, max2(WC_CYC, 2) - 1));
   localparam int unsigned SU_CYC  = 1;
   localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned MAX_CYC = max2(max2(RD_CYC, PUL_CYC), HZ_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: address and data widths must be non-zero");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: clock period must be at least 1 ns");
   end

   phase_e            phase_q, phase_d;
   logic              t_load, t_done, accept, capture;
   logic [CNT_W-1:0]  t_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              rsp_q;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   always_comb begin
      phase_d = phase_q;
      t_load  = 1'b0;
      t_val   = '0;
      accept  = 1'b0;
      capture = 1'b0;
      case (phase_q)
         PH_IDLE: if (req_valid) begin
            accept = 1'b1;
            t_load = 1'b1;
            if (req_write) begin
               phase_d = PH_WSU;
               t_val   = CNT_W'(SU_CYC - 1);
            end else begin
               phase_d = PH_RD;
               t_val   = CNT_W'(RD_CYC - 1);
            end
         end
         PH_RD: if (t_done) begin
            capture = 1'b1;
            phase_d = PH_TURN;
            t_load  = 1'b1;
            t_val   = CNT_W'(HZ_CYC - 1);
         end
         PH_WSU: if (t_done) begin
            phase_d = PH_WPUL;
            t_load  = 1'b1;
            t_val   = CNT_W'(PUL_CYC - 1);
         end
         PH_WPUL: if (t_done) begin
            phase_d = PH_TURN;
            t_load  = 1'b1;
            t_val   = CNT_W'(HZ_CYC - 1);
         end
         PH_TURN: if (t_done) phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         rsp_q   <= capture;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= sram_dq_in;
      end
   end

   sram_pin_drv u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_nxt (phase_d),
      .cs_n      (sram_cs_n),
      .cs2       (sram_cs2),
      .oe_n      (sram_oe_n),
      .we_n      (sram_we_n),
      .dq_oe     (sram_dq_oe)
   );

   assign req_ready   = (phase_q == PH_IDLE);
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;
   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;

   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_strobe_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> ($past(!sram_oe_n) && sram_oe_n));
   assert_busy_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_cs_n |-> !req_ready);
   assert_turn_before_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> ($past(sram_cs_n) && sram_cs_n));
   assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));
   assert_read_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));
endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
   localparam int CLK_NS = 8;
   localparam int RD_CYC = 7;   // ceil(55/8)
   localparam int PUL_CYC = 6;  // max(5, 3, 6-1, 7-1)
   localparam int HZ_CYC = 3;   // ceil(20/8)

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [7:0] rsp_rdata;
   logic [15:0] sram_addr;
   logic sram_cs_n, sram_cs2, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [7:0] sram_dq_in = '0, sram_dq_out;

   always #(CLK_NS/2) clk = ~clk;

   sram_async_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_cs2(sram_cs2), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_in(sram_dq_in), .sram_dq_out(sram_dq_out),
      .sram_dq_oe(sram_dq_oe)
   );

   int n_tests = 0, n_fail = 0;
   longint cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory model (ns timing) ----------------
   logic [7:0] mem [logic [15:0]];
   realtime t_sel = 0, t_rd = 0, t_rd_end = -1000, t_addr = 0, t_wst = 0, t_wd = 0;
   bit sel_q = 0, rd_q = 0, wr_q = 0, oe_q = 0;
   logic [15:0] addr_q = '0, w_addr = '0;
   logic [7:0] wd = '0;

   function automatic logic [7:0] mem_rd(logic [15:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   always @(sram_dq_out, sram_dq_oe) begin
      if (sram_dq_oe && (!oe_q || sram_dq_out != wd)) begin
         t_wd = $realtime;
         wd = sram_dq_out;
      end
      oe_q = sram_dq_oe;
   end

   always @(sram_cs_n, sram_cs2, sram_oe_n, sram_we_n, sram_addr) begin
      bit sel, rd, wr;
      realtime now;
      now = $realtime;
      sel = !sram_cs_n && sram_cs2;
      rd  = sel && !sram_oe_n && sram_we_n;
      wr  = sel && !sram_we_n;
      if (sram_addr != addr_q) begin
         if (wr_q) chk(0, "R9 addr changed in write", sram_addr, addr_q);
         if (rd_q) chk(now - t_addr >= 55.0, "R9 read cycle", longint'(now - t_addr), 55);
         t_addr = now;
         addr_q = sram_addr;
      end
      if (sel && !sel_q) t_sel = now;
      if (rd && !rd_q) t_rd = now;
      if (!rd && rd_q) begin
         chk(now - t_rd >= 55.0, "R9 read access length", longint'(now - t_rd), 55);
         t_rd_end = now;
      end
      if (wr && !wr_q) begin
         t_wst = now;
         w_addr = sram_addr;
      end
      if (!wr && wr_q) begin
         chk(now - t_wst >= 40.0, "R9 write pulse", longint'(now - t_wst), 40);
         chk(now - t_sel >= 45.0, "R9 select window", longint'(now - t_sel), 45);
         chk(now - t_wd  >= 20.0, "R9 data setup", longint'(now - t_wd), 20);
         chk(now - t_addr >= 55.0, "R9 write cycle", longint'(now - t_addr), 55);
         mem[w_addr] = wd;
      end
      sel_q = sel; rd_q = rd; wr_q = wr;
   end

   initial begin
      #0.5;
      forever begin
         realtime now;
         bit drv;
         logic [7:0] v;
         now = $realtime;
         drv = (rd_q && now - t_rd >= 5.0) || (!rd_q && now - t_rd_end < 20.0);
         v = mem_rd(sram_addr);
         if (!(rd_q && now - t_rd >= 55.0 && now - t_addr >= 55.0)) v = ~v;
         if (drv && sram_dq_oe) chk(0, "R9 bus contention", 1, 0);
         sram_dq_in = drv ? v : (sram_dq_oe ? sram_dq_out : 8'h00);
         #1;
      end
   end

   // ---------------- scoreboard ----------------
   logic [7:0] shadow [logic [15:0]];
   logic [7:0] exp_q [$];
   longint due_q [$];

   task automatic xfer(bit w, logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      if (w) shadow[a] = d;
      else begin
         exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
         due_q.push_back(cyc + 1 + RD_CYC);
      end
      @(negedge clk);
      req_valid = 0;
   endtask

   // monitor: responses and strobe run lengths
   int oe_run = 0, we_run = 0, gap_run = 0;
   bit prev_rsp = 0, prev_ready = 1, prev_su = 0;
   always @(negedge clk) if (rst_n && !finished) begin
      if (rsp_valid) begin
         chk(!prev_rsp, "R4 single-cycle strobe", 1, 0);
         if (exp_q.size() == 0) chk(0, "R4 unexpected response", rsp_rdata, 0);
         else begin
            logic [7:0] e;
            longint du;
            e = exp_q.pop_front();
            du = due_q.pop_front();
            chk(rsp_rdata == e, "R9 readback data", rsp_rdata, e);
            chk(cyc == du, "R2 read latency", cyc, du);
         end
      end
      prev_rsp = rsp_valid;
      if (!sram_oe_n) begin
         oe_run++;
         chk(!sram_cs_n && sram_cs2 && sram_we_n && !sram_dq_oe, "R3 read pins", 0, 1);
      end else if (oe_run != 0) begin
         chk(oe_run == RD_CYC, "R3 read length", oe_run, RD_CYC);
         oe_run = 0;
      end
      if (!sram_we_n) begin
         if (we_run == 0) chk(prev_su, "R5 setup cycle before pulse", prev_su, 1);
         we_run++;
      end else if (we_run != 0) begin
         chk(we_run == PUL_CYC, "R5 pulse length", we_run, PUL_CYC);
         we_run = 0;
      end
      prev_su = !sram_cs_n && sram_cs2 && sram_we_n && sram_oe_n;
      if (sram_dq_oe) chk(!sram_we_n, "R6 drive only with write enable", sram_we_n, 0);
      if (!sram_oe_n) chk(sram_we_n, "R6 oe/we exclusive", sram_we_n, 1);
      if (!sram_cs_n) chk(!req_ready, "R8 ready low when selected", req_ready, 0);
      if (!req_ready && sram_cs_n) gap_run++;
      if (req_ready && !prev_ready) chk(gap_run == HZ_CYC, "R7 turnaround", gap_run, HZ_CYC);
      if (req_ready) gap_run = 0;
      prev_ready = req_ready;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [15:0] addrs [40];
      repeat (3) @(negedge clk);
      chk(sram_cs_n && !sram_cs2 && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 reset pins", 0, 1);
      chk(!rsp_valid, "R1 reset rsp_valid", rsp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(sram_cs_n && !sram_cs2 && sram_oe_n && sram_we_n, "R1 idle pins", 0, 1);
      // R8: a request held off while busy is taken once ready returns
      xfer(1, 16'h0000, 8'h00);
      xfer(1, 16'hFFFF, 8'hFF);
      xfer(0, 16'h0000, 8'h00);
      xfer(0, 16'hFFFF, 8'h00);
      xfer(1, 16'h1234, 8'hA5);
      xfer(0, 16'h1234, 8'h00);
      xfer(1, 16'h1234, 8'h5A);  // overwrite then readback
      xfer(0, 16'h1234, 8'h00);
      xfer(0, 16'h4321, 8'h00);  // never written
      lfsr = 16'hACE1;
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         addrs[i] = lfsr;
         xfer(1, lfsr, lfsr[7:0] ^ lfsr[15:8]);
      end
      for (int i = 39; i >= 0; i--) xfer(0, addrs[i], 8'h00);
      repeat (RD_CYC + HZ_CYC + 4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 0);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule